// File: doc/BRIEF.md
# RGB to YCbCr 4:2:2 Converter

This block turns a stream of 24-bit RGB pixels, one pixel per beat with 8 bits for each channel, into a stream of YCbCr pixel pairs with 4:2:2 chroma. Each output beat holds two luma samples and one shared Cb/Cr pair. Every output component is a weighted sum of R, G and B. The nine weights are two's-complement values with 8 fractional bits. Each sum is rounded to an integer, an offset is added, and the result is limited to a programmable range. Luma and chroma have separate offsets and separate ranges.

Both sides of the block use a valid/ready handshake. The configuration inputs (weights, offsets, limits, filter mode) are static levels. They may change only while no pixel is inside the pipeline. A two-bit mode selects how the two chroma values of a pair are reduced to one. With the usual studio-range settings the block produces standard video levels: Y runs from 16 to 235, and Cb and Cr run from 16 to 240, centred on 128.

Top module: `ycc422_conv`

## Requirements
- R1: For each accepted pixel, Y = floor((Wyr*R + Wyg*G + Wyb*B + 128) / 256) + y_off, before the limit is applied. The weights are signed Q8 values.
- R2: Each pixel's Cb and Cr are formed the same way, using their own three weights and the shared offset c_off, before filtering and limiting.
- R3: After filtering, Y is limited to [y_min, y_max], and Cb and Cr are limited to [c_min, c_max]. A value below the low limit becomes the low limit, and a value above the high limit becomes the high limit.
- R4: `coef` packs nine 10-bit two's-complement weights, weight k at bits [10k+9:10k]. For k = 0 to 8 the order is: Y from R, Y from G, Y from B; Cb from R, Cb from G, Cb from B; Cr from R, Cr from G, Cr from B.
- R5: The first pixel accepted after reset is the even pixel of a pair. Each two accepted pixels give exactly one output beat, with out_y0 from the even pixel and out_y1 from the odd pixel.
- R6: filt_mode selects the chroma of the pair: 0 takes the even pixel's value; 1 takes the odd pixel's value; 2 takes floor((even+odd)/2); 3 takes floor((even+odd+1)/2). The filter is applied to unlimited values.
- R7: With out_ready held high, the output beat appears on out_valid two clock edges after the edge that accepts the odd pixel.
- R8: While out_valid is high and out_ready is low, all outputs hold their values and in_ready is low.
- R9: Reset clears out_valid, raises in_ready and returns the pairing to the even pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block accepts a pixel at this edge |
| in_r | input | 8 | Red component |
| in_g | input | 8 | Green component |
| in_b | input | 8 | Blue component |
| coef | input | 90 | Nine packed signed Q8 weights |
| y_off | input | 8 | Luma offset |
| c_off | input | 8 | Chroma offset |
| y_min | input | 8 | Luma low limit |
| y_max | input | 8 | Luma high limit |
| c_min | input | 8 | Chroma low limit |
| c_max | input | 8 | Chroma high limit |
| filt_mode | input | 2 | Chroma subsample mode |
| out_valid | output | 1 | Output pair valid |
| out_ready | input | 1 | Downstream accepts the pair |
| out_y0 | output | 8 | Luma of even pixel |
| out_y1 | output | 8 | Luma of odd pixel |
| out_cb | output | 8 | Shared Cb of the pair |
| out_cr | output | 8 | Shared Cr of the pair |

## Verification
A pair becomes due two edges after the edge that takes its odd pixel: one edge for the products, one for the rounded sums, and one for the filtered and limited output register. A directed test drives out_ready high, sends two pixels and checks that out_valid is still low after the first of those two edges and high after the second. In the random runs every output beat is compared with the next entry of an in-order expected queue, only when the beat is actually transferred, so stalls never shift the comparison. A beat held under backpressure is checked again one cycle later for unchanged values.

// File: rtl/ycc_pkg.sv
package ycc_pkg;
  typedef enum logic [1:0] {
    FILT_EVEN    = 2'd0,
    FILT_ODD     = 2'd1,
    FILT_AVG_DN  = 2'd2,
    FILT_AVG_RND = 2'd3
  } filt_mode_e;

  localparam int LANES = 3;
endpackage

// File: rtl/ycc_mac.sv
module ycc_mac import ycc_pkg::*; #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 10,
  parameter int FRAC_W = 8,
  parameter int RES_W  = COEF_W + PIX_W + 4 - FRAC_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     in_vld,
  input  logic [PIX_W-1:0]         r,
  input  logic [PIX_W-1:0]         g,
  input  logic [PIX_W-1:0]         b,
  input  logic [LANES*COEF_W-1:0]  coef,
  input  logic [PIX_W-1:0]         offs,
  output logic                     out_vld,
  output logic signed [RES_W-1:0]  res
);
  localparam int PROD_W = COEF_W + PIX_W + 1;
  localparam int SUM_W  = PROD_W + 2;
  localparam int HI_W   = SUM_W - FRAC_W;

  logic [PIX_W-1:0]         pix [LANES];
  logic signed [PROD_W-1:0] prod_q [LANES];
  logic                     vld1;
  logic signed [SUM_W-1:0]  acc;
  logic [HI_W-1:0]          acc_hi;
  logic [FRAC_W-2:0]        frac_unused;
  logic [RES_W-1:0]         res_d;

  assign pix[0] = r;
  assign pix[1] = g;
  assign pix[2] = b;

  // stage 1: one product per colour channel
  always_ff @(posedge clk) begin
    if (rst) begin
      vld1 <= 1'b0;
      for (int k = 0; k < LANES; k++) prod_q[k] <= '0;
    end else if (en) begin
      vld1 <= in_vld;
      for (int k = 0; k < LANES; k++)
        prod_q[k] <= $signed(coef[k*COEF_W +: COEF_W]) * $signed({1'b0, pix[k]});
    end
  end

  // stage 2: sum, round to nearest (half up), add offset
  always_comb begin
    acc = {{2{prod_q[0][PROD_W-1]}}, prod_q[0]}
        + {{2{prod_q[1][PROD_W-1]}}, prod_q[1]}
        + {{2{prod_q[2][PROD_W-1]}}, prod_q[2]};
    acc_hi      = acc[SUM_W-1:FRAC_W];
    frac_unused = acc[FRAC_W-2:0];
    res_d = {acc_hi[HI_W-1], acc_hi}
          + RES_W'(acc[FRAC_W-1])
          + {{(RES_W-PIX_W){1'b0}}, offs};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      res     <= '0;
    end else if (en) begin
      out_vld <= vld1;
      res     <= $signed(res_d);
    end
  end

  // R7: a product stage that advances always fills the sum stage
  p_stage_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (en && vld1) |=> out_vld);
  // R8: a stalled lane keeps its result
  p_lane_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!en && out_vld) |=> (out_vld && $stable(res)));
endmodule

// File: rtl/ycc_pair.sv
module ycc_pair import ycc_pkg::*; #(
  parameter int PIX_W = 8,
  parameter int RES_W = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    in_vld,
  input  logic signed [RES_W-1:0] y_in,
  input  logic signed [RES_W-1:0] cb_in,
  input  logic signed [RES_W-1:0] cr_in,
  input  logic [1:0]              mode,
  input  logic [PIX_W-1:0]        y_min,
  input  logic [PIX_W-1:0]        y_max,
  input  logic [PIX_W-1:0]        c_min,
  input  logic [PIX_W-1:0]        c_max,
  output logic                    out_vld,
  output logic [PIX_W-1:0]        y0,
  output logic [PIX_W-1:0]        y1,
  output logic [PIX_W-1:0]        cb,
  output logic [PIX_W-1:0]        cr
);
  logic                    phase_q;
  logic signed [RES_W-1:0] hold_y, hold_cb, hold_cr;
  logic signed [RES_W-1:0] cb_sel, cr_sel;

  function automatic logic [PIX_W-1:0] clip(input logic signed [RES_W-1:0] v,
                                             input logic [PIX_W-1:0] lo,
                                             input logic [PIX_W-1:0] hi);
    if (v < $signed({{(RES_W-PIX_W){1'b0}}, lo}))      return lo;
    else if (v > $signed({{(RES_W-PIX_W){1'b0}}, hi})) return hi;
    else                                               return v[PIX_W-1:0];
  endfunction

  function automatic logic signed [RES_W-1:0] pick(input filt_mode_e m,
                                                    input logic signed [RES_W-1:0] a,
                                                    input logic signed [RES_W-1:0] bb);
    logic [RES_W:0] s;
    s = {a[RES_W-1], a} + {bb[RES_W-1], bb};
    case (m)
      FILT_EVEN:   return a;
      FILT_ODD:    return bb;
      FILT_AVG_DN: return $signed(s[RES_W:1]);
      default:     return $signed(s[RES_W:1] + RES_W'(s[0]));
    endcase
  endfunction

  always_comb begin
    cb_sel = pick(filt_mode_e'(mode), hold_cb, cb_in);
    cr_sel = pick(filt_mode_e'(mode), hold_cr, cr_in);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      out_vld <= 1'b0;
      hold_y  <= '0;
      hold_cb <= '0;
      hold_cr <= '0;
      y0 <= '0;
      y1 <= '0;
      cb <= '0;
      cr <= '0;
    end else if (en) begin
      out_vld <= in_vld & phase_q;
      if (in_vld) begin
        phase_q <= ~phase_q;
        if (!phase_q) begin
          hold_y  <= y_in;
          hold_cb <= cb_in;
          hold_cr <= cr_in;
        end else begin
          y0 <= clip(hold_y, y_min, y_max);
          y1 <= clip(y_in, y_min, y_max);
          cb <= clip(cb_sel, c_min, c_max);
          cr <= clip(cr_sel, c_min, c_max);
        end
      end
    end
  end

  // R5: odd pixel produces a beat, even pixel does not
  p_odd_emits_r5: assert property (@(posedge clk) disable iff (rst)
    (en && in_vld && phase_q) |=> out_vld);
  p_even_silent_r5: assert property (@(posedge clk) disable iff (rst)
    (en && in_vld && !phase_q) |=> !out_vld);
  // R3: luma and chroma inside their limits while the limits are steady
  p_y_range_r3: assert property (@(posedge clk) disable iff (rst)
    (out_vld && $stable(y_min) && $stable(y_max) && (y_min <= y_max)) |->
      (y0 >= y_min && y0 <= y_max && y1 >= y_min && y1 <= y_max));
  p_c_range_r3: assert property (@(posedge clk) disable iff (rst)
    (out_vld && $stable(c_min) && $stable(c_max) && (c_min <= c_max)) |->
      (cb >= c_min && cb <= c_max && cr >= c_min && cr <= c_max));
endmodule

// File: rtl/ycc422_conv.sv
module ycc422_conv import ycc_pkg::*; #(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 10,
  parameter int FRAC_W = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [PIX_W-1:0]              in_r,
  input  logic [PIX_W-1:0]              in_g,
  input  logic [PIX_W-1:0]              in_b,
  input  logic [LANES*LANES*COEF_W-1:0] coef,
  input  logic [PIX_W-1:0]              y_off,
  input  logic [PIX_W-1:0]              c_off,
  input  logic [PIX_W-1:0]              y_min,
  input  logic [PIX_W-1:0]              y_max,
  input  logic [PIX_W-1:0]              c_min,
  input  logic [PIX_W-1:0]              c_max,
  input  logic [1:0]                    filt_mode,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [PIX_W-1:0]              out_y0,
  output logic [PIX_W-1:0]              out_y1,
  output logic [PIX_W-1:0]              out_cb,
  output logic [PIX_W-1:0]              out_cr
);
  localparam int RES_W  = COEF_W + PIX_W + 4 - FRAC_W;
  localparam int ROW_W  = LANES * COEF_W;

  logic                    adv;
  logic signed [RES_W-1:0] ch_res [LANES];
  logic [LANES-1:0]        ch_vld;
  logic [LANES-2:0]        side_vld_unused;

  // whole pipeline moves together unless a finished beat is blocked
  assign adv             = ~out_valid | out_ready;
  assign in_ready        = adv;
  assign side_vld_unused = ch_vld[LANES-1:1];

  for (genvar c = 0; c < LANES; c++) begin : g_lane
    ycc_mac #(
      .PIX_W (PIX_W),
      .COEF_W(COEF_W),
      .FRAC_W(FRAC_W),
      .RES_W (RES_W)
    ) u_mac (
      .clk    (clk),
      .rst    (rst),
      .en     (adv),
      .in_vld (in_valid),
      .r      (in_r),
      .g      (in_g),
      .b      (in_b),
      .coef   (coef[c*ROW_W +: ROW_W]),
      .offs   ((c == 0) ? y_off : c_off),
      .out_vld(ch_vld[c]),
      .res    (ch_res[c])
    );
  end

  ycc_pair #(
    .PIX_W(PIX_W),
    .RES_W(RES_W)
  ) u_pair (
    .clk    (clk),
    .rst    (rst),
    .en     (adv),
    .in_vld (ch_vld[0]),
    .y_in   (ch_res[0]),
    .cb_in  (ch_res[1]),
    .cr_in  (ch_res[2]),
    .mode   (filt_mode),
    .y_min  (y_min),
    .y_max  (y_max),
    .c_min  (c_min),
    .c_max  (c_max),
    .out_vld(out_valid),
    .y0     (out_y0),
    .y1     (out_y1),
    .cb     (out_cb),
    .cr     (out_cr)
  );

  // R8: a blocked beat stays put and input is refused
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_y0) && $stable(out_y1) && $stable(out_cb) && $stable(out_cr)));
  p_backpressure_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
  // R9: after reset nothing is pending
  p_reset_idle_r9: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);
endmodule

// File: tb/tb_ycc422_conv.sv
module tb_ycc422_conv;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, in_valid, in_ready, out_valid, out_ready;
  logic [7:0]  in_r, in_g, in_b;
  logic [89:0] coef;
  logic [7:0]  y_off, c_off, y_min, y_max, c_min, c_max;
  logic [1:0]  filt_mode;
  logic [7:0]  out_y0, out_y1, out_cb, out_cr;

  ycc422_conv dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_r(in_r), .in_g(in_g), .in_b(in_b), .coef(coef),
    .y_off(y_off), .c_off(c_off), .y_min(y_min), .y_max(y_max),
    .c_min(c_min), .c_max(c_max), .filt_mode(filt_mode),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_y0(out_y0), .out_y1(out_y1), .out_cb(out_cb), .out_cr(out_cr)
  );

  typedef struct { int y0; int y1; int cb; int cr; } pair_t;
  pair_t exp_q[$];
  int  n_chk = 0, n_bad = 0;
  bit  ph = 0;
  int  ev_y, ev_cb, ev_cr;
  localparam logic [89:0] DEF_COEF = {10'h3EE, 10'h3A2, 10'h070,
                                      10'h070, 10'h3B6, 10'h3DB,
                                      10'h019, 10'h081, 10'h041};

  function automatic int sc(int k);
    int v;
    v = int'(coef[k*10 +: 10]);
    if (v >= 512) v -= 1024;
    return v;
  endfunction

  function automatic int lane(int c, int r, int g, int b);
    int s;
    s = sc(3*c)*r + sc(3*c+1)*g + sc(3*c+2)*b;
    return ((s + 128) >>> 8) + ((c == 0) ? int'(y_off) : int'(c_off));
  endfunction

  function automatic int clip(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic int pick(int a, int b);
    case (filt_mode)
      2'd0:    return a;
      2'd1:    return b;
      2'd2:    return (a + b) >>> 1;
      default: return (a + b + 1) >>> 1;
    endcase
  endfunction

  task automatic model_accept(int r, int g, int b);
    int y, cb, cr;
    pair_t e;
    y = lane(0, r, g, b); cb = lane(1, r, g, b); cr = lane(2, r, g, b);
    if (!ph) begin
      ev_y = y; ev_cb = cb; ev_cr = cr;
    end else begin
      e.y0 = clip(ev_y, y_min, y_max);
      e.y1 = clip(y, y_min, y_max);
      e.cb = clip(pick(ev_cb, cb), c_min, c_max);
      e.cr = clip(pick(ev_cr, cr), c_min, c_max);
      exp_q.push_back(e);
    end
    ph = ~ph;
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_out(string tag);
    pair_t e;
    if (exp_q.size() == 0) begin
      chk(1'b0, {tag, " R5 unexpected beat"}, int'(out_y0), -1);
      return;
    end
    e = exp_q.pop_front();
    chk(int'(out_y0) == e.y0, {tag, " R1 y0"}, int'(out_y0), e.y0);
    chk(int'(out_y1) == e.y1, {tag, " R1 y1"}, int'(out_y1), e.y1);
    chk(int'(out_cb) == e.cb, {tag, " R2 cb"}, int'(out_cb), e.cb);
    chk(int'(out_cr) == e.cr, {tag, " R2 cr"}, int'(out_cr), e.cr);
  endtask

  task automatic run(int n, int pv, int pr, int kind, string tag);
    int  sent = 0;
    bit  acc = 0, hold = 0;
    logic [31:0] snap;
    in_valid = 0;
    while (sent < n || exp_q.size() > 0) begin
      @(negedge clk);
      if (acc) begin in_valid = 0; acc = 0; end
      if (!in_valid && sent < n && int'($urandom % 100) < pv) begin
        in_valid = 1;
        if (kind == 1) begin
          in_r = ($urandom % 2) ? 8'hFF : 8'h00;
          in_g = ($urandom % 2) ? 8'hFF : 8'h00;
          in_b = ($urandom % 2) ? 8'hFF : 8'h00;
        end else begin
          in_r = 8'($urandom); in_g = 8'($urandom); in_b = 8'($urandom);
        end
      end
      out_ready = int'($urandom % 100) < pr;
      #1;
      if (hold) begin
        chk(out_valid && {out_y0, out_y1, out_cb, out_cr} == snap,
            {tag, " R8 hold"}, int'({out_y0, out_y1, out_cb, out_cr}), int'(snap));
        hold = 0;
      end
      if (out_valid) begin
        if (out_ready) compare_out(tag);
        else begin
          chk(!in_ready, {tag, " R8 stall"}, int'(in_ready), 0);
          hold = 1;
          snap = {out_y0, out_y1, out_cb, out_cr};
        end
      end
      if (in_valid && in_ready) begin
        model_accept(int'(in_r), int'(in_g), int'(in_b));
        sent++;
        acc = 1;
      end
    end
    @(negedge clk);
    in_valid = 0;
    out_ready = 1;
  endtask

  // two pixels back to back with out_ready high; timing and hand-worked values
  task automatic lat_test(logic [23:0] pa, logic [23:0] pb, pair_t e, string tag);
    @(negedge clk);
    out_ready = 1; in_valid = 1; {in_r, in_g, in_b} = pa;
    @(negedge clk);
    {in_r, in_g, in_b} = pb;
    @(negedge clk);                 // odd pixel taken at the edge before
    in_valid = 0;
    #1;
    chk(!out_valid, {tag, " R7 too early +0"}, int'(out_valid), 0);
    @(negedge clk); #1;
    chk(!out_valid, {tag, " R7 too early +1"}, int'(out_valid), 0);
    @(negedge clk); #1;
    chk(out_valid, {tag, " R7 due at +2"}, int'(out_valid), 1);
    exp_q.push_back(e);
    compare_out(tag);
    @(negedge clk); #1;
    chk(!out_valid, {tag, " R5 single beat"}, int'(out_valid), 0);
  endtask

  task automatic do_reset();
    rst = 1;
    in_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    exp_q.delete();
    ph = 0;
    #1;
    chk(!out_valid, "R9 out_valid after reset", int'(out_valid), 0);
    chk(in_ready, "R9 in_ready after reset", int'(in_ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    pair_t e;
    void'($urandom(32'd20240611));
    coef = DEF_COEF; y_off = 8'd16; c_off = 8'd128;
    y_min = 8'd16; y_max = 8'd235; c_min = 8'd16; c_max = 8'd240;
    filt_mode = 2'd3; out_ready = 0;
    in_r = 0; in_g = 0; in_b = 0;
    do_reset();

    // black then white, default weights, mode 3: Y 16/234, Cb avg(128,129)=129, Cr 128
    e.y0 = 16; e.y1 = 234; e.cb = 129; e.cr = 128;
    lat_test(24'h000000, 24'hFFFFFF, e, "R1/R6 default black-white");

    run(200, 70, 70, 0, "R1/R2/R6 mode3 random");
    run(60, 100, 100, 1, "R1/R2 extremes full rate");
    filt_mode = 2'd0; run(100, 60, 80, 0, "R6 mode0");
    filt_mode = 2'd1; run(100, 80, 60, 0, "R6 mode1");
    filt_mode = 2'd2; run(100, 90, 40, 0, "R6 mode2");

    // odd pixel count before a reset: pairing must restart on the even pixel
    @(negedge clk); out_ready = 1; in_valid = 1; in_r = 8'd200; in_g = 8'd10; in_b = 8'd90;
    @(negedge clk); in_valid = 0;
    repeat (4) @(negedge clk);
    do_reset();
    filt_mode = 2'd3;
    run(40, 100, 100, 0, "R9/R5 pairing after reset");

    // random weights and offsets
    for (int k = 0; k < 9; k++) coef[k*10 +: 10] = 10'($urandom);
    y_off = 8'($urandom); c_off = 8'($urandom);
    run(150, 75, 75, 0, "R4 random weights");

    // random limits together with random weights, saturating stimulus
    for (int k = 0; k < 9; k++) coef[k*10 +: 10] = 10'($urandom);
    y_min = 8'($urandom % 128); y_max = 8'(128 + $urandom % 128);
    c_min = 8'($urandom % 128); c_max = 8'(128 + $urandom % 128);
    run(150, 75, 75, 1, "R3/R4 random limits");

    // saturation by hand: Y weights +511, Cb weights -512, Cr default, mode 1
    y_min = 8'd16; y_max = 8'd235; c_min = 8'd16; c_max = 8'd240;
    y_off = 8'd16; c_off = 8'd128;
    coef = DEF_COEF;
    coef[29:0] = {10'h1FF, 10'h1FF, 10'h1FF};
    coef[59:30] = {10'h200, 10'h200, 10'h200};
    filt_mode = 2'd1;
    e.y0 = 16; e.y1 = 235; e.cb = 16; e.cr = 128;
    lat_test(24'h000000, 24'hFFFFFF, e, "R3 saturation");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule